// File: doc/BRIEF.md
# LED Driver Display Data Register Bank

This block holds the display data of a sixteen-channel constant-current LED driver. Ten-bit words arrive side by side on a parallel bus, one word per qualified clock, and move through one of three shift chains. One chain holds a gray-scale word for each channel. One holds a single brightness word. One holds a seven-bit dot-correction value for each channel. A two-bit select input picks the chain that shifts and the latch that a strobe loads. A strobe copies that chain into its holding latch, and the latch feeds the output stage.

The brightness word is stored with its bits rotated: the top input bit becomes the least significant bit of the current-adjust field. The word then splits into a clock-divider field and a current field. Both configuration latches have an enable input. When the enable is low, the latch output shows a fixed default value in place of the stored one. A strobe to a configuration latch is ignored while the outputs are lit. The last stage of the selected chain drives a ten-bit output so that several devices can be chained. PWM counting and the analog stage are outside this block.

Top module: `led_data_bank`

## Requirements
- R1: After 16 gray-scale shifts and a strobe, the first word shifted in appears on channel 0 and the sixteenth on channel 15. Channel k occupies `gs_out[k*10 +: 10]`.
- R2: The gray-scale chain advances by one whole word on each clock where `shift_en` is high and `sel` is 0. The new word enters at the channel-15 end.
- R3: `cascade_out` shows the last stage of the selected chain. That stage holds the word shifted in 16 shifts earlier; for the dot-correction chain it is zero-extended to 10 bits.
- R4: A gray-scale strobe (`sel` = 0) loads the latch whatever the level of `blank`. The latch keeps its value until the next such strobe.
- R5: For a stored brightness word d, `bc_cur` = {d[5:0], d[9]} and `bc_div` = d[8:6].
- R6: While `bc_en` is low, `bc_div` reads 0 and `bc_cur` reads 7'h7F. When `bc_en` returns high, the stored value shows again.
- R7: The dot-correction chain takes `din[6:0]` per shift (`sel` = 2). After 16 shifts and a strobe, the first word is on channel 0 at `dc_out[k*7 +: 7]`.
- R8: While `dc_en` is low, every dot-correction channel reads 7'h7F.
- R9: While `blank` is low, strobes with `sel` = 1 or 2 leave the brightness and dot-correction latches unchanged. The same strobes take effect once `blank` is high.
- R10: With `sel` = 3 no chain shifts and no latch loads, and `cascade_out` reads 0.
- R11: An active-low `rst_n` clears every chain and latch to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Chain select: 0 gray scale, 1 brightness, 2 dot correction, 3 none |
| shift_en | input | 1 | Shifts the selected chain by one word |
| din | input | 10 | Parallel input word, bit 9 is the MSB |
| latch_stb | input | 1 | Copies the selected chain into its latch |
| blank | input | 1 | High while the outputs are off |
| bc_en | input | 1 | Low forces the brightness default |
| dc_en | input | 1 | Low forces the dot-correction default |
| cascade_out | output | 10 | Last stage of the selected chain |
| gs_out | output | 160 | Latched gray-scale words, channel 0 in the low bits |
| bc_div | output | 3 | Gray-scale clock divider field |
| bc_cur | output | 7 | Reference current adjust field |
| dc_out | output | 112 | Latched dot-correction values, channel 0 in the low bits |

## Verification
The gray-scale chain is loaded with two different 16-word patterns. A mismatch in channel order or in how far the chain moves on each shift shows up as words on the wrong channels. A short extra load then checks the cascade output, which tells a chain that moves a whole word per clock apart from one that moves by bits. Brightness values with uneven bit patterns show whether the rotated field mapping is correct. The dot-correction load drives non-zero upper bus bits to prove they are dropped. Strobes are repeated with `blank` low and then high, which separates a blocked update from a lost or a stale one.

// File: rtl/led_bank_pkg.sv
package led_bank_pkg;
    localparam int WORD_W   = 10;
    localparam int CHANNELS = 16;
    localparam int DC_W     = 7;
    localparam int DIV_W    = 3;

    typedef enum logic [1:0] {
        SEL_GRAY   = 2'd0,
        SEL_BRIGHT = 2'd1,
        SEL_DOT    = 2'd2,
        SEL_NONE   = 2'd3
    } chain_sel_e;

    typedef struct packed {
        logic gs_shift;
        logic gs_load;
        logic bc_shift;
        logic bc_load;
        logic dc_shift;
        logic dc_load;
    } chain_ctl_t;
endpackage

// File: rtl/led_bank_decode.sv
module led_bank_decode
    import led_bank_pkg::*;
(
    input  logic [1:0]  sel,
    input  logic        shift_en,
    input  logic        latch_stb,
    input  logic        blank,
    output chain_ctl_t  ctl
);
    chain_sel_e which;
    chain_ctl_t ctl_d;

    assign which = chain_sel_e'(sel);

    always_comb begin
        ctl_d = '0;
        unique case (which)
            SEL_GRAY: begin
                ctl_d.gs_shift = shift_en;
                ctl_d.gs_load  = latch_stb;
            end
            SEL_BRIGHT: begin
                ctl_d.bc_shift = shift_en;
                ctl_d.bc_load  = latch_stb & blank;
            end
            SEL_DOT: begin
                ctl_d.dc_shift = shift_en;
                ctl_d.dc_load  = latch_stb & blank;
            end
            default: ctl_d = '0;
        endcase
    end

    assign ctl = ctl_d;
endmodule

// File: rtl/led_word_chain.sv
module led_word_chain #(
    parameter int W     = 10,
    parameter int DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift,
    input  logic                 load,
    input  logic [W-1:0]         din,
    output logic [W*DEPTH-1:0]   chain_q,
    output logic [W*DEPTH-1:0]   lat_q,
    output logic [W-1:0]         tail
);
    localparam int BITS = W * DEPTH;

    typedef struct packed {
        logic [BITS-1:0] sr;
        logic [BITS-1:0] lat;
    } chain_t;

    chain_t          st_d, st_q;
    logic [BITS-1:0] shifted;

    generate
        if (DEPTH > 1) begin : g_multi
            assign shifted = {din, st_q.sr[BITS-1:W]};
        end else begin : g_single
            assign shifted = din;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (shift) st_d.sr  = shifted;
        if (load)  st_d.lat = st_q.sr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chain_q = st_q.sr;
    assign lat_q   = st_q.lat;
    assign tail    = st_q.sr[W-1:0];
endmodule

// File: rtl/led_cfg_default.sv
module led_cfg_default #(
    parameter int          W   = 7,
    parameter logic [W-1:0] DEF = '1
) (
    input  logic [W-1:0] stored,
    input  logic         en,
    output logic [W-1:0] shown
);
    always_comb begin
        shown = en ? stored : DEF;
    end
endmodule

// File: rtl/led_data_bank.sv
module led_data_bank
    import led_bank_pkg::*;
#(
    parameter int WW  = WORD_W,
    parameter int CH  = CHANNELS,
    parameter int DW  = DC_W,
    parameter int DVW = DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel,
    input  logic              shift_en,
    input  logic [WW-1:0]     din,
    input  logic              latch_stb,
    input  logic              blank,
    input  logic              bc_en,
    input  logic              dc_en,
    output logic [WW-1:0]     cascade_out,
    output logic [WW*CH-1:0]  gs_out,
    output logic [DVW-1:0]    bc_div,
    output logic [WW-DVW-1:0] bc_cur,
    output logic [DW*CH-1:0]  dc_out
);
    localparam int CUR_W = WW - DVW;
    localparam logic [WW-1:0] BC_DEF = {{DVW{1'b0}}, {CUR_W{1'b1}}};

    chain_ctl_t         ctl;
    logic [WW*CH-1:0]   gs_chain;
    logic [WW-1:0]      gs_tail;
    logic [WW-1:0]      bc_chain, bc_raw, bc_tail, bc_rot, bc_shown;
    logic [DW*CH-1:0]   dc_chain, dc_raw;
    logic [DW-1:0]      dc_tail;

    led_bank_decode u_dec (
        .sel       (sel),
        .shift_en  (shift_en),
        .latch_stb (latch_stb),
        .blank     (blank),
        .ctl       (ctl)
    );

    led_word_chain #(.W(WW), .DEPTH(CH)) u_gs (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (ctl.gs_shift),
        .load    (ctl.gs_load),
        .din     (din),
        .chain_q (gs_chain),
        .lat_q   (gs_out),
        .tail    (gs_tail)
    );

    led_word_chain #(.W(WW), .DEPTH(1)) u_bc (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (ctl.bc_shift),
        .load    (ctl.bc_load),
        .din     (din),
        .chain_q (bc_chain),
        .lat_q   (bc_raw),
        .tail    (bc_tail)
    );

    led_word_chain #(.W(DW), .DEPTH(CH)) u_dc (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (ctl.dc_shift),
        .load    (ctl.dc_load),
        .din     (din[DW-1:0]),
        .chain_q (dc_chain),
        .lat_q   (dc_raw),
        .tail    (dc_tail)
    );

    // Brightness word: top input bit rotates down to the current-field LSB.
    assign bc_rot = {bc_raw[WW-2:0], bc_raw[WW-1]};

    led_cfg_default #(.W(WW), .DEF(BC_DEF)) u_bc_def (
        .stored (bc_rot),
        .en     (bc_en),
        .shown  (bc_shown)
    );

    assign bc_div = bc_shown[WW-1 -: DVW];
    assign bc_cur = bc_shown[CUR_W-1:0];

    generate
        for (genvar k = 0; k < CH; k++) begin : g_dc_def
            led_cfg_default #(.W(DW), .DEF({DW{1'b1}})) u_def (
                .stored (dc_raw[k*DW +: DW]),
                .en     (dc_en),
                .shown  (dc_out[k*DW +: DW])
            );
        end
    endgenerate

    always_comb begin
        unique case (chain_sel_e'(sel))
            SEL_GRAY:   cascade_out = gs_tail;
            SEL_BRIGHT: cascade_out = bc_tail;
            SEL_DOT:    cascade_out = {{(WW-DW){1'b0}}, dc_tail};
            default:    cascade_out = '0;
        endcase
    end

    logic unused_ok;
    assign unused_ok = ^{bc_chain, dc_chain};
endmodule

// File: rtl/led_data_bank_chk.sv
module led_data_bank_chk #(
    parameter int WW  = 10,
    parameter int CH  = 16,
    parameter int DW  = 7,
    parameter int DVW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        sel,
    input logic              shift_en,
    input logic [WW-1:0]     din,
    input logic              latch_stb,
    input logic              blank,
    input logic              bc_en,
    input logic              dc_en,
    input logic [DVW-1:0]    bc_div,
    input logic [WW-DVW-1:0] bc_cur,
    input logic [DW*CH-1:0]  dc_out,
    input logic [WW*CH-1:0]  gs_out,
    input logic [WW*CH-1:0]  gs_chain,
    input logic [WW-1:0]     bc_raw,
    input logic [DW*CH-1:0]  dc_raw
);
    a_r9_bc_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |=> $stable(bc_raw));

    a_r9_dc_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |=> $stable(dc_raw));

    a_r6_bc_default: assert property (@(posedge clk) disable iff (!rst_n)
        !bc_en |-> (bc_div == '0 && bc_cur == '1));

    a_r8_dc_default: assert property (@(posedge clk) disable iff (!rst_n)
        !dc_en |-> (dc_out == '1));

    a_r1_gs_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_stb && sel == 2'd0) |=> gs_out == $past(gs_chain));

    a_r2_word_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && sel == 2'd0) |=> gs_chain[WW*CH-1 -: WW] == $past(din));

    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd3) |=> ($stable(gs_chain) && $stable(gs_out)
                           && $stable(bc_raw) && $stable(dc_raw)));
endmodule

bind led_data_bank led_data_bank_chk #(.WW(WW), .CH(CH), .DW(DW), .DVW(DVW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .shift_en  (shift_en),
    .din       (din),
    .latch_stb (latch_stb),
    .blank     (blank),
    .bc_en     (bc_en),
    .dc_en     (dc_en),
    .bc_div    (bc_div),
    .bc_cur    (bc_cur),
    .dc_out    (dc_out),
    .gs_out    (gs_out),
    .gs_chain  (gs_chain),
    .bc_raw    (bc_raw),
    .dc_raw    (dc_raw)
);

// File: tb/led_data_bank_test.sv
`timescale 1ns/1ps
module led_data_bank_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   sel = 2'd0;
    logic         shift_en = 1'b0;
    logic [9:0]   din = '0;
    logic         latch_stb = 1'b0;
    logic         blank = 1'b0;
    logic         bc_en = 1'b1;
    logic         dc_en = 1'b1;
    logic [9:0]   cascade_out;
    logic [159:0] gs_out;
    logic [2:0]   bc_div;
    logic [6:0]   bc_cur;
    logic [111:0] dc_out;

    always #5 clk = ~clk;

    led_data_bank uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .shift_en(shift_en), .din(din),
        .latch_stb(latch_stb), .blank(blank), .bc_en(bc_en), .dc_en(dc_en),
        .cascade_out(cascade_out), .gs_out(gs_out), .bc_div(bc_div),
        .bc_cur(bc_cur), .dc_out(dc_out)
    );

    typedef struct {
        string        req;
        int           kind;
        logic [159:0] exp;
    } item_t;

    item_t  sb[$];
    int     n_tests = 0;
    int     n_fail  = 0;
    bit     done    = 0;

    // kind: 0 gs_out, 1 {bc_div,bc_cur}, 2 dc_out, 3 cascade_out
    task automatic expect_val(string req, int kind, logic [159:0] v);
        item_t it;
        it.req = req; it.kind = kind; it.exp = v;
        sb.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [159:0] got;
                it = sb.pop_front();
                case (it.kind)
                    0:       got = gs_out;
                    1:       got = {150'b0, bc_div, bc_cur};
                    2:       got = {48'b0, dc_out};
                    default: got = {150'b0, cascade_out};
                endcase
                n_tests++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
                end
            end
        end
    end

    task automatic step(logic [1:0] m, logic sh, logic [9:0] d, logic stb);
        sel = m; shift_en = sh; din = d; latch_stb = stb;
        @(posedge clk); #1;
        shift_en = 1'b0; latch_stb = 1'b0;
    endtask

    task automatic drain();
        @(posedge clk); #1;
    endtask

    function automatic logic [159:0] bc_exp(logic [9:0] d);
        return {150'b0, d[8:6], d[5:0], d[9]};
    endfunction

    logic [9:0]   wa [16];
    logic [9:0]   wb [16];
    logic [6:0]   wd [16];
    logic [6:0]   we [16];
    logic [159:0] ga, gb;
    logic [111:0] da, de;

    initial begin : driver
        for (int i = 0; i < 16; i++) begin
            wa[i] = 10'((i * 37 + 5) & 10'h3FF);
            wb[i] = 10'h3FF ^ 10'(1 << (i % 10)) ^ 10'(i);
            wd[i] = 7'((i * 9 + 3) & 7'h7F);
            we[i] = 7'((i * 5 + 1) & 7'h7F);
            ga[i*10 +: 10] = wa[i];
            gb[i*10 +: 10] = wb[i];
            da[i*7 +: 7]   = wd[i];
            de[i*7 +: 7]   = we[i];
        end

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11: reset state
        expect_val("R11 gs reset", 0, '0);
        expect_val("R11 bc reset", 1, '0);
        expect_val("R11 dc reset", 2, '0);
        expect_val("R11 cascade reset", 3, '0);
        drain();

        // Gray pattern A, outputs lit
        for (int i = 0; i < 16; i++) step(2'd0, 1'b1, wa[i], 1'b0);
        expect_val("R3 cascade gray first word", 3, {150'b0, wa[0]});
        expect_val("R4 gs holds before strobe", 0, '0);
        drain();
        step(2'd0, 1'b0, '0, 1'b1);
        expect_val("R1 gs order pattern A (R4 lit)", 0, ga);
        drain();

        // Gray pattern B, outputs off
        blank = 1'b1;
        for (int i = 0; i < 16; i++) step(2'd0, 1'b1, wb[i], 1'b0);
        step(2'd0, 1'b0, '0, 1'b1);
        expect_val("R1 gs order pattern B", 0, gb);
        drain();
        for (int i = 0; i < 3; i++) step(2'd0, 1'b1, 10'(i + 100), 1'b0);
        expect_val("R2 whole-word advance", 3, {150'b0, wb[3]});
        expect_val("R4 gs held while shifting", 0, gb);
        drain();

        // R10: select none
        step(2'd3, 1'b1, 10'h155, 1'b1);
        step(2'd3, 1'b1, 10'h2AA, 1'b1);
        expect_val("R10 cascade zero", 3, '0);
        expect_val("R10 gs latch untouched", 0, gb);
        drain();
        sel = 2'd0;
        expect_val("R10 gs chain untouched", 3, {150'b0, wb[3]});
        drain();

        // Brightness, outputs off
        step(2'd1, 1'b1, 10'h2C5, 1'b0);
        step(2'd1, 1'b0, '0, 1'b1);
        expect_val("R5 bc mapping 2C5", 1, bc_exp(10'h2C5));
        drain();
        step(2'd1, 1'b1, 10'h13A, 1'b0);
        expect_val("R3 cascade brightness", 3, {150'b0, 10'h13A});
        drain();
        step(2'd1, 1'b0, '0, 1'b1);
        expect_val("R5 bc mapping 13A", 1, bc_exp(10'h13A));
        drain();
        bc_en = 1'b0;
        expect_val("R6 bc default", 1, {150'b0, 3'b000, 7'h7F});
        drain();
        bc_en = 1'b1;
        expect_val("R6 bc restored", 1, bc_exp(10'h13A));
        drain();

        // Dot correction, outputs off, upper bus bits non-zero
        for (int i = 0; i < 16; i++) step(2'd2, 1'b1, {3'b101, wd[i]}, 1'b0);
        expect_val("R3 cascade dot first word", 3, {153'b0, wd[0]});
        drain();
        step(2'd2, 1'b0, '0, 1'b1);
        expect_val("R7 dc order", 2, {48'b0, da});
        drain();
        dc_en = 1'b0;
        expect_val("R8 dc default", 2, {48'b0, {112{1'b1}}});
        drain();
        dc_en = 1'b1;

        // R9: interlock while lit
        blank = 1'b0;
        step(2'd1, 1'b1, 10'h0F0, 1'b0);
        step(2'd1, 1'b0, '0, 1'b1);
        expect_val("R9 bc blocked while lit", 1, bc_exp(10'h13A));
        drain();
        for (int i = 0; i < 16; i++) step(2'd2, 1'b1, {3'b010, we[i]}, 1'b0);
        step(2'd2, 1'b0, '0, 1'b1);
        expect_val("R9 dc blocked while lit", 2, {48'b0, da});
        drain();
        blank = 1'b1;
        step(2'd1, 1'b0, '0, 1'b1);
        expect_val("R9 bc loads when off", 1, bc_exp(10'h0F0));
        drain();
        step(2'd2, 1'b0, '0, 1'b1);
        expect_val("R9 dc loads when off", 2, {48'b0, de});
        drain();
        expect_val("R4 gs unaffected by config strobes", 0, gb);
        drain();

        drain();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule